// File: doc/BRIEF.md
# Routed Multi-Section Arithmetic Pipeline

This block is a 64-bit arithmetic pipeline with eight fixed sections in a row: receiver, exponent subtract, align, add, normalize, multiply, accumulate and output. One set of sections serves three operations. The opcode of each item decides which sections do work on it. Every other section passes the item through as a plain register stage, so all operations have the same depth and results leave in the order they were issued.

An upstream sequencer offers one operand pair per clock, together with an opcode and first/last markers for dot products. A floating add uses the exponent subtract, align, add and normalize sections. A fixed multiply uses the multiply section. A dot product chains the multiply section into a running sum held in the accumulate section, and reports that sum once, when the last element arrives. A shared stall input freezes every section at once and loses nothing.

Top module: `arith_pipe`

## Requirements
- R1: `in_op` selects the operation: 2'b00 floating add, 2'b01 fixed multiply, 2'b10 dot product. `out_op` carries the opcode of the item whose result is on `out_data`.
- R2: A floating word has the sign in bit 63, an excess-64 binary exponent in bits 62:56 and a 56-bit fraction in bits 55:0. Operands are normalized (fraction bit 55 set) or all-zero. The pipeline shifts the smaller-magnitude operand right by the exponent difference, dropping the bits that fall off (a shift of 56 or more leaves zero). It then adds or subtracts the fractions, and the result takes the sign of the larger-magnitude operand.
- R3: A floating result is normalized. A carry out of the fraction shifts the fraction right by one and adds one to the exponent. Otherwise the fraction is shifted left until bit 55 is set, and the exponent is lowered by the same count. A zero sum, or an exponent that would drop below 0, gives an all-zero word.
- R4: Fixed multiply takes bits 31:0 of each operand as signed two's-complement numbers, ignores bits 63:32, and returns the full 64-bit signed product.
- R5: Dot product multiplies each pair as in R4. An element with `in_first` set starts a new sum from its own product, and every other element adds its product to the running sum (64-bit, wrapping). Only an element with `in_last` set produces a result, which is the sum including that element. Elements of other operations between dot elements leave the sum unchanged.
- R6: An item accepted at a rising edge appears with `out_valid` high after the 8th non-stalled rising edge, counting the accepting edge. Items issued back to back give one result per clock, in issue order.
- R7: While `stall` is high, no input is accepted and no section advances. `out_valid` is low in the cycle after a stalled edge, and `out_data` holds its value. Every item in flight still appears after the stall ends.
- R8: After reset the pipeline is empty and `out_valid` is low.
- R9: Opcode 2'b11 is reserved. An item offered with it produces no result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| stall | input | 1 | Freeze all sections |
| in_valid | input | 1 | Operand pair offered this cycle |
| in_op | input | 2 | Operation code |
| in_first | input | 1 | First element of a dot product |
| in_last | input | 1 | Last element of a dot product |
| in_a | input | 64 | Operand A |
| in_b | input | 64 | Operand B |
| out_valid | output | 1 | Result present (one-cycle pulse) |
| out_op | output | 2 | Opcode of the result |
| out_data | output | 64 | Result word |

## Verification
Every result is due exactly eight non-stalled rising edges after the edge that accepted it, counting that edge. A dot product is due eight edges after its last element. The bench keeps its own count of edges at which `stall` was low. Each expected item is stamped with the count its accepting edge will produce, and when a result appears the monitor checks that the count has advanced by exactly seven since that stamp. A result that comes early, late or out of order, or whose data or opcode is wrong, is caught the moment it appears. Stalls are placed both while results are in flight and while an input is being offered, so the latency stamp also shows that frozen cycles do not count.

// File: rtl/arith_pipe_pkg.sv
package arith_pipe_pkg;
  localparam int DW  = 64;              // data word width
  localparam int EW  = 7;               // exponent width
  localparam int FW  = 56;              // fraction width
  localparam int MW  = 32;              // fixed multiply operand width
  localparam int LZW = $clog2(FW + 1);  // leading-zero count width

  typedef enum logic [1:0] {
    OP_FADD = 2'b00,
    OP_IMUL = 2'b01,
    OP_DOT  = 2'b10,
    OP_RSVD = 2'b11
  } op_e;

  // Item travelling through the sections; fields a section does not use pass unchanged.
  typedef struct packed {
    logic          vld;
    op_e           op;
    logic          first;
    logic          last;
    logic [DW-1:0] a;
    logic [DW-1:0] b;
    logic          sgn;
    logic          sub;
    logic [EW-1:0] exp;
    logic [EW-1:0] shamt;
    logic [FW-1:0] big_f;
    logic [FW-1:0] sml_f;
    logic [FW:0]   sum;
    logic [DW-1:0] res;
  } lane_t;
endpackage

// File: rtl/arith_front.sv
// Sections 1..3: receiver, exponent subtract, align.
module arith_front
  import arith_pipe_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          in_valid,
  input  logic [1:0]    in_op,
  input  logic          in_first,
  input  logic          in_last,
  input  logic [DW-1:0] in_a,
  input  logic [DW-1:0] in_b,
  output lane_t         s3_q
);
  lane_t s1_d, s1_q, s2_d, s2_q, s3_d;
  logic [DW-2:0] mag_a, mag_b;
  logic [DW-1:0] big_w, sml_w;
  logic          swap;

  // receiver
  always_comb begin
    s1_d       = '0;
    s1_d.vld   = in_valid && (in_op != OP_RSVD);
    s1_d.op    = op_e'(in_op);
    s1_d.first = in_first;
    s1_d.last  = in_last;
    s1_d.a     = in_a;
    s1_d.b     = in_b;
  end

  // exponent subtract: order by magnitude, form the shift distance
  always_comb begin
    mag_a = s1_q.a[DW-2:0];
    mag_b = s1_q.b[DW-2:0];
    swap  = mag_b > mag_a;
    big_w = swap ? s1_q.b : s1_q.a;
    sml_w = swap ? s1_q.a : s1_q.b;
    s2_d  = s1_q;
    if (s1_q.op == OP_FADD) begin
      s2_d.sgn   = big_w[DW-1];
      s2_d.sub   = big_w[DW-1] ^ sml_w[DW-1];
      s2_d.exp   = big_w[DW-2 -: EW];
      s2_d.shamt = big_w[DW-2 -: EW] - sml_w[DW-2 -: EW];
      s2_d.big_f = big_w[FW-1:0];
      s2_d.sml_f = sml_w[FW-1:0];
    end
  end

  // align: shift the smaller fraction right, truncating
  always_comb begin
    s3_d = s2_q;
    if (s2_q.op == OP_FADD) begin
      if (s2_q.shamt >= EW'(FW)) s3_d.sml_f = '0;
      else                       s3_d.sml_f = s2_q.sml_f >> s2_q.shamt;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_q <= '0;
      s2_q <= '0;
      s3_q <= '0;
    end else if (en) begin
      s1_q <= s1_d;
      s2_q <= s2_d;
      s3_q <= s3_d;
    end
  end
endmodule

// File: rtl/arith_addnorm.sv
// Sections 4..5: add, normalize.
module arith_addnorm
  import arith_pipe_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  en,
  input  lane_t s3_q,
  output lane_t s5_q
);
  lane_t s4_d, s4_q, s5_d;
  logic [LZW-1:0] lz;

  function automatic logic [LZW-1:0] lead_zeros(input logic [FW-1:0] v);
    logic [LZW-1:0] n;
    n = LZW'(FW);
    for (int i = 0; i < FW; i++) begin
      if (v[i]) n = LZW'(FW - 1 - i);
    end
    return n;
  endfunction

  // add / subtract magnitudes
  always_comb begin
    s4_d = s3_q;
    if (s3_q.op == OP_FADD) begin
      if (s3_q.sub) s4_d.sum = {1'b0, s3_q.big_f} - {1'b0, s3_q.sml_f};
      else          s4_d.sum = {1'b0, s3_q.big_f} + {1'b0, s3_q.sml_f};
    end
  end

  // normalize
  always_comb begin
    s5_d = s4_q;
    lz   = lead_zeros(s4_q.sum[FW-1:0]);
    if (s4_q.op == OP_FADD) begin
      if (s4_q.sum == '0)
        s5_d.res = '0;
      else if (s4_q.sum[FW])
        s5_d.res = {s4_q.sgn, s4_q.exp + EW'(1), s4_q.sum[FW:1]};
      else if (s4_q.exp < EW'(lz))
        s5_d.res = '0;
      else
        s5_d.res = {s4_q.sgn, s4_q.exp - EW'(lz), s4_q.sum[FW-1:0] << lz};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s4_q <= '0;
      s5_q <= '0;
    end else if (en) begin
      s4_q <= s4_d;
      s5_q <= s5_d;
    end
  end
endmodule

// File: rtl/arith_mulacc.sv
// Sections 6..7: multiply, accumulate.
module arith_mulacc
  import arith_pipe_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  en,
  input  lane_t s5_q,
  output lane_t s7_q
);
  lane_t s6_d, s6_q, s7_d;
  logic [DW-1:0] opa_x, opb_x, acc_q, acc_d;

  // multiply: sign-extended low halves, low DW bits of the product
  always_comb begin
    opa_x = {{(DW-MW){s5_q.a[MW-1]}}, s5_q.a[MW-1:0]};
    opb_x = {{(DW-MW){s5_q.b[MW-1]}}, s5_q.b[MW-1:0]};
    s6_d  = s5_q;
    if (s5_q.op != OP_FADD) s6_d.res = opa_x * opb_x;
  end

  // accumulate: running sum for dot products only
  always_comb begin
    acc_d = acc_q;
    s7_d  = s6_q;
    if (s6_q.vld && s6_q.op == OP_DOT) begin
      acc_d    = s6_q.first ? s6_q.res : acc_q + s6_q.res;
      s7_d.res = acc_d;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s6_q  <= '0;
      s7_q  <= '0;
      acc_q <= '0;
    end else if (en) begin
      s6_q  <= s6_d;
      s7_q  <= s7_d;
      acc_q <= acc_d;
    end
  end
endmodule

// File: rtl/arith_pipe.sv
module arith_pipe
  import arith_pipe_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          stall,
  input  logic          in_valid,
  input  logic [1:0]    in_op,
  input  logic          in_first,
  input  logic          in_last,
  input  logic [DW-1:0] in_a,
  input  logic [DW-1:0] in_b,
  output logic          out_valid,
  output logic [1:0]    out_op,
  output logic [DW-1:0] out_data
);
  lane_t s3_q, s5_q, s7_q;
  logic  en;

  assign en = !stall;

  arith_front u_front (
    .clk(clk), .rst(rst), .en(en),
    .in_valid(in_valid), .in_op(in_op), .in_first(in_first), .in_last(in_last),
    .in_a(in_a), .in_b(in_b), .s3_q(s3_q)
  );

  arith_addnorm u_addnorm (
    .clk(clk), .rst(rst), .en(en), .s3_q(s3_q), .s5_q(s5_q)
  );

  arith_mulacc u_mulacc (
    .clk(clk), .rst(rst), .en(en), .s5_q(s5_q), .s7_q(s7_q)
  );

  // output section: one-cycle valid pulse, data held through stalls
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_op    <= '0;
      out_data  <= '0;
    end else if (stall) begin
      out_valid <= 1'b0;
    end else begin
      out_valid <= s7_q.vld && (s7_q.op != OP_DOT || s7_q.last);
      if (s7_q.vld) begin
        out_op   <= s7_q.op;
        out_data <= s7_q.res;
      end
    end
  end
endmodule

// File: rtl/arith_pipe_chk.sv
module arith_pipe_chk
  import arith_pipe_pkg::*;
(
  input logic          clk,
  input logic          rst,
  input logic          stall,
  input logic          out_valid,
  input logic [1:0]    out_op,
  input logic [DW-1:0] out_data
);
  // R7: a stalled edge leaves no result pulse behind it
  p_stall_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    stall |=> !out_valid);

  // R7: output word is frozen across a stalled edge
  p_stall_hold_r7: assert property (@(posedge clk) disable iff (rst)
    stall |=> $stable(out_data));

  // R3: nonzero floating results carry a set leading fraction bit
  p_norm_msb_r3: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_op == OP_FADD && out_data != '0) |-> out_data[FW-1]);

  // R3: a zero fraction is only ever reported as the all-zero word
  p_zero_clean_r3: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_op == OP_FADD && out_data[FW-1:0] == '0) |-> (out_data == '0));

  // R9: reserved opcode never reaches the output
  p_no_rsvd_r9: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_op != OP_RSVD));
endmodule

bind arith_pipe arith_pipe_chk u_chk (.*);

// File: tb/arith_pipe_bench.sv
`timescale 1ns/1ps
module arith_pipe_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        stall = 1'b0;
  logic        in_valid = 1'b0;
  logic [1:0]  in_op = 2'b00;
  logic        in_first = 1'b0;
  logic        in_last = 1'b0;
  logic [63:0] in_a = '0;
  logic [63:0] in_b = '0;
  logic        out_valid;
  logic [1:0]  out_op;
  logic [63:0] out_data;

  int checks = 0;
  int errors = 0;
  int adv = 0;
  bit done = 1'b0;

  typedef struct {
    logic [1:0]  op;
    logic [63:0] data;
    int          tag;
    string       rq;
  } exp_t;
  exp_t q[$];

  always #4 clk = ~clk;

  arith_pipe u_arith_pipe (
    .clk(clk), .rst(rst), .stall(stall), .in_valid(in_valid), .in_op(in_op),
    .in_first(in_first), .in_last(in_last), .in_a(in_a), .in_b(in_b),
    .out_valid(out_valid), .out_op(out_op), .out_data(out_data)
  );

  // count of non-stalled edges since reset
  always @(posedge clk) begin
    if (rst) adv <= 0;
    else if (!stall) adv <= adv + 1;
  end

  function automatic logic [63:0] fp(input logic s, input int e, input logic [55:0] f);
    return {s, 7'(e), f};
  endfunction

  function automatic logic [63:0] fadd_ref(input logic [63:0] a, input logic [63:0] b);
    int ea, eb, em, e;
    logic [55:0] va, vb;
    logic signed [60:0] s;
    logic [60:0] mag;
    ea = int'(a[62:56]);
    eb = int'(b[62:56]);
    em = (ea > eb) ? ea : eb;
    va = ((em - ea) >= 56) ? 56'd0 : a[55:0] >> (em - ea);
    vb = ((em - eb) >= 56) ? 56'd0 : b[55:0] >> (em - eb);
    s  = (a[63] ? -$signed({5'd0, va}) : $signed({5'd0, va})) +
         (b[63] ? -$signed({5'd0, vb}) : $signed({5'd0, vb}));
    mag = (s < 0) ? 61'(-s) : 61'(s);
    if (mag == 0) return 64'd0;
    e = em;
    if (mag[56]) begin
      mag = mag >> 1;
      e = e + 1;
    end else begin
      while (!mag[55]) begin
        mag = mag << 1;
        e = e - 1;
        if (e < 0) return 64'd0;
      end
    end
    return {(s < 0), 7'(e), mag[55:0]};
  endfunction

  function automatic logic [63:0] mul_ref(input logic [63:0] a, input logic [63:0] b);
    longint x, y;
    x = longint'($signed(a[31:0]));
    y = longint'($signed(b[31:0]));
    return 64'(x * y);
  endfunction

  task automatic check(input bit ok, input string rq, input string what,
                       input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, expv);
    end
  endtask

  // driver: offer one item at the next negedge, stall low
  task automatic send(input logic [1:0] op, input logic [63:0] a, input logic [63:0] b,
                      input logic f, input logic l, input bit push,
                      input logic [63:0] ev, input string rq);
    exp_t it;
    @(negedge clk);
    in_valid = 1'b1; in_op = op; in_a = a; in_b = b; in_first = f; in_last = l;
    if (push) begin
      it.op = op; it.data = ev; it.tag = adv + 1; it.rq = rq;
      q.push_back(it);
    end
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    in_valid = 1'b0; in_first = 1'b0; in_last = 1'b0;
    repeat (n - 1) @(negedge clk);
  endtask

  task automatic fadd(input logic [63:0] a, input logic [63:0] b, input string rq);
    send(2'b00, a, b, 1'b0, 1'b0, 1'b1, fadd_ref(a, b), rq);
  endtask

  task automatic imul(input logic [63:0] a, input logic [63:0] b, input string rq);
    send(2'b01, a, b, 1'b0, 1'b0, 1'b1, mul_ref(a, b), rq);
  endtask

  task automatic drain;
    int n = 0;
    idle(1);
    while (q.size() != 0 && n < 60) begin
      @(negedge clk);
      n++;
    end
    check(q.size() == 0, "R6", "all results delivered", 64'(q.size()), 64'd0);
  endtask

  // monitor: compare results against the scoreboard as they appear
  always @(negedge clk) begin
    exp_t it;
    if (!rst && out_valid) begin
      if (q.size() == 0) begin
        check(1'b0, "R9", "unexpected result", out_data, 64'd0);
      end else begin
        it = q.pop_front();
        check(out_data == it.data, it.rq, "data", out_data, it.data);
        check(out_op == it.op, "R1", "opcode", 64'(out_op), 64'(it.op));
        check((adv - it.tag) == 7, "R6", "latency", 64'(adv - it.tag), 64'd7);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [55:0] one = 56'h80_0000_0000_0000;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0, "R8", "idle after reset", 64'(out_valid), 64'd0);

    // R2/R3 floating add cases, back to back (R6)
    fadd(fp(0, 64, one), fp(0, 64, one), "R3");                         // carry
    fadd(fp(0, 64, 56'hC0_0000_0000_0000), fp(0, 62, one), "R2");       // 1.5+0.25
    fadd(fp(0, 70, 56'h91_2345_6789_ABCD), fp(1, 70, 56'h91_2345_6789_ABCD), "R3"); // to zero
    fadd(fp(0, 64, 56'h80_0000_0000_0001), fp(1, 64, one), "R3");      // deep left shift
    fadd(fp(0, 3, 56'h80_0000_0000_0001), fp(1, 3, one), "R3");        // underflow
    fadd(fp(0, 66, 56'hA0_0000_0000_0000), fp(1, 67, 56'hF0_0000_0000_0000), "R2"); // negative
    fadd(fp(0, 100, one), fp(0, 30, 56'hFF_FFFF_FFFF_FFFF), "R2");      // far shift
    fadd(64'd0, fp(1, 50, 56'hB0_0000_0000_1234), "R2");                // zero operand
    fadd(fp(1, 80, 56'h80_0000_0000_0003), fp(0, 79, 56'hFF_FFFF_FFFF_FFFE), "R2");
    drain();

    // R4 fixed multiply
    imul(64'd7, 64'hFFFF_FFFF_FFFF_FFFD, "R4");
    imul(64'h7FFF_FFFF, 64'h7FFF_FFFF, "R4");
    imul(64'h8000_0000, 64'h8000_0000, "R4");
    imul(64'hDEAD_BEEF_0000_0005, 64'h1234_5678_FFFF_FFFA, "R4");       // upper halves ignored
    drain();

    // R5 dot product: [1,2,3,4].[5,6,7,8] = 70, with a multiply in between
    send(2'b10, 64'd1, 64'd5, 1'b1, 1'b0, 1'b0, 64'd0, "R5");
    send(2'b10, 64'd2, 64'd6, 1'b0, 1'b0, 1'b0, 64'd0, "R5");
    imul(64'd9, 64'd9, "R4");
    send(2'b10, 64'd3, 64'd7, 1'b0, 1'b0, 1'b0, 64'd0, "R5");
    send(2'b10, 64'd4, 64'd8, 1'b0, 1'b1, 1'b1, 64'd70, "R5");
    // fresh sum starts from its own product: -3*4 + 10*10 = 88
    send(2'b10, 64'hFFFF_FFFD, 64'd4, 1'b1, 1'b0, 1'b0, 64'd0, "R5");
    send(2'b10, 64'd10, 64'd10, 1'b0, 1'b1, 1'b1, 64'd88, "R5");
    // single-element dot product
    send(2'b10, 64'd6, 64'hFFFF_FFFF, 1'b1, 1'b1, 1'b1, 64'hFFFF_FFFF_FFFF_FFFA, "R5");
    drain();

    // R9 reserved opcode between real items
    imul(64'd3, 64'd11, "R1");
    send(2'b11, 64'd5, 64'd5, 1'b0, 1'b0, 1'b0, 64'd0, "R9");
    fadd(fp(0, 64, one), fp(0, 63, one), "R1");
    drain();

    // R7 stall with results in flight
    imul(64'd100, 64'd200, "R7");
    fadd(fp(0, 65, one), fp(1, 64, one), "R7");
    imul(64'hFFFF_FFFF, 64'd1, "R7");
    idle(3);
    @(negedge clk);
    stall = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check(out_valid == 1'b0, "R7", "no pulse while stalled", 64'(out_valid), 64'd0);
    end
    stall = 1'b0;
    drain();

    // R7 input offered during stall is taken only once
    @(negedge clk);
    stall = 1'b1;
    in_valid = 1'b1; in_op = 2'b01; in_a = 64'd12; in_b = 64'd13;
    repeat (3) @(negedge clk);
    begin
      exp_t it;
      it.op = 2'b01; it.data = 64'd156; it.tag = adv + 1; it.rq = "R7";
      q.push_back(it);
    end
    stall = 1'b0;
    drain();

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule